// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block watches a 32-pin general-purpose input port and raises an interrupt request when a pin shows a configured event. Each pin can be set to fire on a rising transition, a falling transition, either transition, a high level or a low level. Software sets the trigger mode in three per-pin bit registers: a kind bit (edge or level), a polarity bit, and an any-edge bit. A pin that fires sets a sticky pending bit. Software clears pending bits by writing ones to a clear register.

Two status views are readable. The raw view shows every pending pin. The masked view hides pins whose mask bit is set. The OR of the masked view drives a single request line to a parent interrupt controller. To initialise, software writes zero to the enable register, zero to the mask register and all ones to the clear register.

The register bus is a plain 32-bit port. A write takes effect at the clock edge where `bus_wr` is high. Read data is combinational from `bus_addr`.

Top module: `gpio_irq_detect`

Per-pin trigger decode, implemented as the enumerated type `trig_e` and selected with a unique case in each pin cell:
- `TRIG_RISE`: kind=0, polarity=0, any-edge=0.
- `TRIG_FALL`: kind=0, polarity=1, any-edge=0.
- `TRIG_BOTH`: kind=0, any-edge=1. The polarity bit is ignored in this mode.
- `TRIG_HIGH`: kind=1, polarity=0.
- `TRIG_LOW`: kind=1, polarity=1.

## Requirements
- R1: After reset, every register reads zero and `irq_o` is low.
- R2: Register offsets and behaviour:
  - The enable (0x20), mask (0x2C), kind (0x34), any-edge (0x38) and polarity (0x3C) registers read back the last value written to them.
  - Writes to raw status (0x24) and masked status (0x28) have no effect.
  - The clear register (0x30) always reads zero.
- R3: With kind=0, polarity=0 and any-edge=0, a pin becomes pending only on a 0-to-1 transition of its input.
- R4: With kind=0, polarity=1 and any-edge=0, a pin becomes pending only on a 1-to-0 transition of its input.
- R5: With kind=0 and any-edge=1, a pin becomes pending on either transition, whatever its polarity bit says.
- R6: With kind=1, a pin becomes pending while its input is high (polarity=0) or low (polarity=1). The pending bit stays set after the level goes away.
- R7: A pin cannot become pending while its enable bit is 0. Input transitions that happen while the pin is disabled leave no pending state behind.
- R8: Writing a 1 to a bit of the clear register clears that pin's pending bit at the write edge. Bits written as 0 are left unchanged.
- R9: A level-mode pin whose active level is still present after a clear shows pending again one clock after the clear edge.
- R10: The masked status equals raw status AND NOT mask. `irq_o` is the OR of the masked status bits.
- R11: A change on an input pin is visible in raw status after the third rising clock edge following the change, and not after the second. Two edges are spent in the synchroniser and one in the pending register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| gpio_i | input | 32 | Asynchronous pin inputs |
| irq_o | output | 1 | Combined request to the parent controller |

## Verification
Each of the five trigger modes is swept with all 32 pins at once, using start/end input pairs chosen so that 0-0, 0-1, 1-0 and 1-1 histories all occur across the pins. This separates rising, falling, both-edge and level behaviour bit by bit. The any-edge sweep runs with polarity set to 1, so an override failure would look like falling-only behaviour. A partial clear pattern, followed by a read one cycle later, separates the clear-then-reassert behaviour of level pins from that of edge pins. A half-word mask and a full mask tell the raw view apart from the masked view and from the request line. A single-pin step, with reads after the second and third edges, pins down the detection latency.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    // Register byte offsets; software addresses depend on these values.
    localparam int OFS_EN   = 'h20;
    localparam int OFS_RAW  = 'h24;
    localparam int OFS_MSK  = 'h28;
    localparam int OFS_MASK = 'h2C;
    localparam int OFS_CLR  = 'h30;
    localparam int OFS_KIND = 'h34;
    localparam int OFS_ANY  = 'h38;
    localparam int OFS_POL  = 'h3C;

    typedef enum logic [2:0] {
        TRIG_RISE = 3'd0,
        TRIG_FALL = 3'd1,
        TRIG_BOTH = 3'd2,
        TRIG_HIGH = 3'd3,
        TRIG_LOW  = 3'd4
    } trig_e;

    // Combine the three per-pin configuration bits into one trigger mode.
    function automatic trig_e decode_trig(input logic kind, input logic pol, input logic any);
        trig_e t;
        if (!kind) begin
            if (any)      t = TRIG_BOTH;
            else if (pol) t = TRIG_FALL;
            else          t = TRIG_RISE;
        end else begin
            t = pol ? TRIG_LOW : TRIG_HIGH;
        end
        return t;
    endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q[0] <= '0;
        end else begin
            stage_q[0] <= async_i;
        end
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[s] <= '0;
            end else begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_irq_cell.sv
module gpio_irq_cell
    import gpio_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_s,
    input  logic en,
    input  logic kind,
    input  logic pol,
    input  logic any,
    input  logic clr,
    output logic pend_o
);

    logic  prev_q;
    logic  pend_q;
    logic  hit;
    trig_e mode;

    // One cycle of input history for edge detection.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= pin_s;
        end
    end

    always_comb begin
        mode = decode_trig(kind, pol, any);
    end

    always_comb begin
        hit = 1'b0;
        unique case (mode)
            TRIG_RISE: hit = pin_s & ~prev_q;
            TRIG_FALL: hit = ~pin_s & prev_q;
            TRIG_BOTH: hit = pin_s ^ prev_q;
            TRIG_HIGH: hit = pin_s;
            TRIG_LOW:  hit = ~pin_s;
            default:   hit = 1'b0;
        endcase
    end

    // Clear has priority over a new event in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (clr) begin
            pend_q <= 1'b0;
        end else if (en && hit) begin
            pend_q <= 1'b1;
        end
    end

    assign pend_o = pend_q;

endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  raw_i,
    input  logic [NPINS-1:0]  masked_i,
    output logic [NPINS-1:0]  en_o,
    output logic [NPINS-1:0]  mask_o,
    output logic [NPINS-1:0]  kind_o,
    output logic [NPINS-1:0]  any_o,
    output logic [NPINS-1:0]  pol_o,
    output logic [NPINS-1:0]  clr_o
);

    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFS_EN);
    localparam logic [ADDR_W-1:0] A_RAW  = ADDR_W'(OFS_RAW);
    localparam logic [ADDR_W-1:0] A_MSK  = ADDR_W'(OFS_MSK);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_CLR);
    localparam logic [ADDR_W-1:0] A_KIND = ADDR_W'(OFS_KIND);
    localparam logic [ADDR_W-1:0] A_ANY  = ADDR_W'(OFS_ANY);
    localparam logic [ADDR_W-1:0] A_POL  = ADDR_W'(OFS_POL);

    logic [NPINS-1:0] wpins;
    logic [NPINS-1:0] en_q, mask_q, kind_q, any_q, pol_q;

    assign wpins = bus_wdata[NPINS-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            mask_q <= '0;
            kind_q <= '0;
            any_q  <= '0;
            pol_q  <= '0;
        end else if (bus_wr) begin
            if (bus_addr == A_EN)   en_q   <= wpins;
            if (bus_addr == A_MASK) mask_q <= wpins;
            if (bus_addr == A_KIND) kind_q <= wpins;
            if (bus_addr == A_ANY)  any_q  <= wpins;
            if (bus_addr == A_POL)  pol_q  <= wpins;
        end
    end

    // Write-one-to-clear pulse, valid only in the write cycle.
    assign clr_o = (bus_wr && bus_addr == A_CLR) ? wpins : '0;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_EN:    bus_rdata = DATA_W'(en_q);
            A_RAW:   bus_rdata = DATA_W'(raw_i);
            A_MSK:   bus_rdata = DATA_W'(masked_i);
            A_MASK:  bus_rdata = DATA_W'(mask_q);
            A_KIND:  bus_rdata = DATA_W'(kind_q);
            A_ANY:   bus_rdata = DATA_W'(any_q);
            A_POL:   bus_rdata = DATA_W'(pol_q);
            default: bus_rdata = '0;
        endcase
    end

    assign en_o   = en_q;
    assign mask_o = mask_q;
    assign kind_o = kind_q;
    assign any_o  = any_q;
    assign pol_o  = pol_q;

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
    parameter int NPINS       = 32,
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  gpio_i,
    output logic              irq_o
);

    logic [NPINS-1:0] pin_s;
    logic [NPINS-1:0] en_q, mask_q, kind_q, any_q, pol_q, clr_p;
    logic [NPINS-1:0] raw_st;
    logic [NPINS-1:0] msk_st;

    gpio_irq_regs #(
        .NPINS (NPINS),
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .raw_i    (raw_st),
        .masked_i (msk_st),
        .en_o     (en_q),
        .mask_o   (mask_q),
        .kind_o   (kind_q),
        .any_o    (any_q),
        .pol_o    (pol_q),
        .clr_o    (clr_p)
    );

    gpio_irq_sync #(
        .WIDTH (NPINS),
        .STAGES(SYNC_STAGES)
    ) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(gpio_i),
        .sync_o (pin_s)
    );

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        gpio_irq_cell cell_i (
            .clk   (clk),
            .rst_n (rst_n),
            .pin_s (pin_s[p]),
            .en    (en_q[p]),
            .kind  (kind_q[p]),
            .pol   (pol_q[p]),
            .any   (any_q[p]),
            .clr   (clr_p[p]),
            .pend_o(raw_st[p])
        );
    end

    assign msk_st = raw_st & ~mask_q;
    assign irq_o  = |msk_st;

endmodule

// File: rtl/gpio_irq_detect_chk.sv
module gpio_irq_detect_chk
    import gpio_irq_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              irq_o,
    input logic [NPINS-1:0]  raw,
    input logic [NPINS-1:0]  masked,
    input logic [NPINS-1:0]  en,
    input logic [NPINS-1:0]  mask
);

    // R8
    clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_CLR)) |=> ((raw & $past(bus_wdata[NPINS-1:0])) == '0));

    // R7
    no_pend_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((raw & ~$past(raw) & ~$past(en)) == '0));

    // R10
    masked_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((masked & mask) == '0) && ((masked | (raw & mask)) == raw));

    // R10
    irq_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == ((raw & ~mask) != '0));

    // R2
    en_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_EN)) |=> (en == $past(bus_wdata[NPINS-1:0])));

endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(
    .NPINS (NPINS),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .irq_o    (irq_o),
    .raw      (raw_st),
    .masked   (msk_st),
    .en       (en_q),
    .mask     (mask_q)
);

// File: tb/gpio_irq_detect_tb_top.sv
module gpio_irq_detect_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] gpio_i = '0;
    logic        irq_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_irq_detect dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .gpio_i   (gpio_i),
        .irq_o    (irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Called at a negedge; the write lands on the next posedge; returns at the following negedge.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v, a_pat, b_pat, exp, lvl, c_pat;
        logic [31:0] pa [3];
        logic [31:0] pb [3];
        logic [7:0]  addrs [8];
        pa[0] = 32'h0F0F0F0F; pb[0] = 32'h00FF00FF;
        pa[1] = 32'hFFFFFFFF; pb[1] = 32'h00000000;
        pa[2] = 32'h12345678; pb[2] = 32'h87654321;
        addrs[0] = 8'h20; addrs[1] = 8'h24; addrs[2] = 8'h28; addrs[3] = 8'h2C;
        addrs[4] = 8'h30; addrs[5] = 8'h34; addrs[6] = 8'h38; addrs[7] = 8'h3C;
        c_pat = 32'h3C3CA5A5;

        idle(3);
        // R1: reset values
        for (int i = 0; i < 8; i++) begin
            rd(addrs[i], v);
            chk("R1 reset reg", v, 32'h0);
        end
        chk("R1 irq reset", {31'b0, irq_o}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        for (int m = 0; m < 5; m++) begin
            for (int p = 0; p < 3; p++) begin
                a_pat = pa[p];
                b_pat = pb[p];
                // Disable, configure, settle inputs at A, clear everything.
                wr(8'h20, 32'h0);
                wr(8'h2C, 32'h0);
                wr(8'h34, (m >= 3) ? 32'hFFFFFFFF : 32'h0);
                wr(8'h3C, (m == 1 || m == 2 || m == 4) ? 32'hFFFFFFFF : 32'h0);
                wr(8'h38, (m == 2) ? 32'hFFFFFFFF : 32'h0);
                gpio_i = a_pat;
                idle(5);
                gpio_i = b_pat;
                idle(5);
                gpio_i = a_pat;
                idle(5);
                wr(8'h30, 32'hFFFFFFFF);
                rd(8'h24, v);
                chk("R7 disabled transitions leave nothing", v, 32'h0);
                rd(8'h34, v);
                chk("R2 kind readback", v, (m >= 3) ? 32'hFFFFFFFF : 32'h0);
                rd(8'h38, v);
                chk("R2 any-edge readback", v, (m == 2) ? 32'hFFFFFFFF : 32'h0);

                wr(8'h20, 32'hFFFFFFFF);
                idle(3);
                gpio_i = b_pat;
                idle(5);
                unique case (m)
                    0: begin exp = ~a_pat & b_pat;   lvl = 32'h0;  end
                    1: begin exp = a_pat & ~b_pat;   lvl = 32'h0;  end
                    2: begin exp = a_pat ^ b_pat;    lvl = 32'h0;  end
                    3: begin exp = a_pat | b_pat;    lvl = b_pat;  end
                    default: begin exp = ~a_pat | ~b_pat; lvl = ~b_pat; end
                endcase
                rd(8'h24, v);
                case (m)
                    0: chk("R3 rising pending", v, exp);
                    1: chk("R4 falling pending", v, exp);
                    2: chk("R5 both-edge overrides polarity", v, exp);
                    default: chk("R6 level pending", v, exp);
                endcase

                // Status registers ignore writes.
                wr(8'h24, 32'hFFFFFFFF);
                wr(8'h28, 32'h0);
                rd(8'h24, v);
                chk("R2 raw ignores writes", v, exp);
                rd(8'h30, v);
                chk("R2 clear reads zero", v, 32'h0);

                // Mask views.
                wr(8'h2C, 32'hFFFF0000);
                rd(8'h28, v);
                chk("R10 masked view", v, exp & 32'h0000FFFF);
                chk("R10 irq with half mask", {31'b0, irq_o}, {31'b0, |(exp & 32'h0000FFFF)});
                wr(8'h2C, 32'hFFFFFFFF);
                chk("R10 irq fully masked", {31'b0, irq_o}, 32'h0);
                rd(8'h24, v);
                chk("R10 raw unaffected by mask", v, exp);
                wr(8'h2C, 32'h0);
                chk("R10 irq unmasked", {31'b0, irq_o}, {31'b0, |exp});

                // Partial clear, then level re-assert one cycle later.
                wr(8'h30, c_pat);
                rd(8'h24, v);
                chk("R8 partial clear", v, exp & ~c_pat);
                @(negedge clk);
                rd(8'h24, v);
                chk("R9 level re-assert", v, (exp & ~c_pat) | lvl);
            end
        end

        // R11: latency through synchroniser and pending register.
        wr(8'h20, 32'h0);
        wr(8'h34, 32'h0);
        wr(8'h3C, 32'h0);
        wr(8'h38, 32'h0);
        gpio_i = 32'h0;
        idle(5);
        wr(8'h30, 32'hFFFFFFFF);
        wr(8'h20, 32'h00000001);
        idle(2);
        gpio_i = 32'h00000001;
        idle(2);
        rd(8'h24, v);
        chk("R11 not pending after two edges", v, 32'h0);
        @(negedge clk);
        rd(8'h24, v);
        chk("R11 pending after third edge", v, 32'h00000001);
        chk("R10 irq raised", {31'b0, irq_o}, 32'h1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule